// File: doc/BRIEF.md
# E1 Receive Resync Criteria and Signaling Alarm Monitor

This block sits behind an E1 receive framer. It watches the framer's per-frame check results and the time slot 16 octet, and turns them into a set of sticky event bits. The framer gives it a valid/error pair for each frame alignment signal word, for each CAS multiframe alignment word and for each CRC-4 submultiframe compare. It also gives a frame strobe carrying that frame's time slot 16 octet, a CAS multiframe boundary strobe, a CRC-4 multiframe boundary strobe and a strobe for each received align frame.

Three of the bits report that a loss-of-alignment criterion has been met. The first is three frame alignment words in error in a row. The second is two CAS alignment words in error in a row. The third is at least 915 CRC-4 errors in a fixed window of 1000 blocks. Two bits report signaling alarms on time slot 16. One is an all-ones test: fewer than three zero bits over 16 frames. The other is an all-zeros test over a whole multiframe. The last two bits are timing marks, one for the CRC-4 multiframe and one for the align frame.

A host clears any bit by writing 1 to it. The low four bits can raise an interrupt through a per-bit mask.

Top module: `e1_rx_alarm_mon`

## Requirements
- R1: A frame alignment word check with error=1, when the two previous valid checks were also errors and no criterion hit has occurred since the run began, sets status bit 4 at the next clock edge. The count then starts again from zero. A valid check with error=0 resets the run.
- R2: Two consecutive CAS alignment word checks in error set status bit 5 at the next edge, and the run then restarts. A correct word resets the run.
- R3: CRC-4 compare results are counted in non-overlapping windows of 1000 valid blocks, starting from reset. On the 1000th block, status bit 6 is set if at least 915 blocks of that window, the current one included, were in error. Both counters then restart.
- R4: Frame strobes are grouped into non-overlapping windows of 16 frames, counted from reset. On the 16th frame, status bit 3 is set if the time slot 16 octets of that window hold fewer than three zero bits in total. This test runs whatever the signaling mode.
- R5: A CAS multiframe boundary is signalled by mf_bnd=1 together with frm_stb=1 on the last frame of the multiframe. On such a frame, status bit 2 is set if that octet and every octet since the previous boundary (or since reset) are 0x00, and at least 15 frames preceded it since that boundary.
- R6: When crc4_en=1, each crcmf_bnd strobe sets status bit 1. When crc4_en=0, crcmf_bnd is ignored, and bit 1 is set instead on every 16th frame strobe of a free-running count from reset.
- R7: Each align frame strobe sets status bit 0 at the next edge.
- R8: After reset every status bit is 0 and irq is 0. Bit 7 always reads 0.
- R9: Status bits stay set until cleared. A cycle with clr_wr=1 clears every bit whose clr_data bit is 1. An event on a bit in the same cycle leaves that bit set.
- R10: irq is 1 exactly when some status bit among bits 3..0 is 1 and its irq_mask bit is 1. Bits 6..4 never drive irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fas_vld | input | 1 | Frame alignment word check result valid |
| fas_err | input | 1 | Frame alignment word received in error |
| cas_vld | input | 1 | CAS alignment word check result valid |
| cas_err | input | 1 | CAS alignment word received in error |
| crc_vld | input | 1 | CRC-4 submultiframe compare result valid |
| crc_err | input | 1 | CRC-4 compare mismatch |
| frm_stb | input | 1 | One pulse per received frame |
| ts16_data | input | 8 | Time slot 16 octet, valid with frm_stb |
| mf_bnd | input | 1 | Last frame of a CAS multiframe (only with frm_stb) |
| crcmf_bnd | input | 1 | CRC-4 multiframe boundary |
| crc4_en | input | 1 | CRC-4 framing enabled |
| algn_stb | input | 1 | Align frame received |
| clr_wr | input | 1 | Host clear write strobe |
| clr_data | input | 8 | Write-1-to-clear mask |
| irq_mask | input | 4 | Interrupt enables for status bits 3..0 |
| status | output | 8 | Latched event bits |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that mf_bnd only ever rises together with frm_stb, and that ts16_data is meaningful only on frame strobes. They also take for granted that the consecutive-error limits are at least two. The bench drives every strobe on the falling edge and asserts mf_bnd only inside a frame strobe cycle, in both the directed and the random phases. It compares every status bit and irq each cycle against a behavioural model built on running counts of frames, zeros and errors.

// File: rtl/e1_alm_pkg.sv
// Shared status bit positions and a helper for the time slot 16 tests.
// Assumes an 8-bit status byte whose low four bits can interrupt.
package e1_alm_pkg;
    localparam int STAT_W    = 8;
    localparam int IRQ_N     = 4;
    localparam int B_ALIGN   = 0;
    localparam int B_CRCMF   = 1;
    localparam int B_SIGZ    = 2;
    localparam int B_SIGO    = 3;
    localparam int B_FASCRIT = 4;
    localparam int B_CASCRIT = 5;
    localparam int B_CRCCRIT = 6;

    // Number of zero bits in an octet.
    function automatic logic [3:0] zero_bits(input logic [7:0] b);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'b000, ~b[i]};
        end
        return n;
    endfunction
endpackage

// File: rtl/e1_consec_err.sv
// Counts consecutive errored check results and pulses hit on the LIMIT-th.
// Assumes LIMIT >= 2; a correct result or a hit restarts the run.
module e1_consec_err #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  logic err,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] run_q;

    // Criterion reached on this check.
    always_comb hit = vld && err && (run_q == CW'(LIMIT - 1));

    // Track the current run of errored checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (vld) begin
            if (!err || hit) run_q <= '0;
            else             run_q <= run_q + 1'b1;
        end
    end

    AST_GOOD_BREAKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !err) |=> !hit); // R1
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < CW'(LIMIT)); // R2
endmodule

// File: rtl/e1_crc_window.sv
// Counts CRC-4 compare errors in fixed, non-overlapping block windows
// and pulses hit when the window closes with at least THRESH errors.
// Assumes THRESH <= WINDOW.
module e1_crc_window #(
    parameter int WINDOW = 1000,
    parameter int THRESH = 915
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  logic err,
    output logic hit
);
    localparam int BW = $clog2(WINDOW + 1);

    logic [BW-1:0] blk_q;
    logic [BW-1:0] ecnt_q;
    logic [BW-1:0] ecnt_nx;
    logic          last;

    // Window close decision including the current block.
    always_comb begin
        ecnt_nx = ecnt_q + BW'(err);
        last    = vld && (blk_q == BW'(WINDOW - 1));
        hit     = last && (ecnt_nx >= BW'(THRESH));
    end

    // Block and error counters, restarted at each window close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            ecnt_q <= '0;
        end else if (vld) begin
            if (last) begin
                blk_q  <= '0;
                ecnt_q <= '0;
            end else begin
                blk_q  <= blk_q + 1'b1;
                ecnt_q <= ecnt_nx;
            end
        end
    end

    AST_ERR_LE_BLK: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt_q <= blk_q); // R3
    AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (blk_q == '0 && ecnt_q == '0)); // R3
endmodule

// File: rtl/e1_ts16_alarm.sv
// Time slot 16 signaling alarm tests and the CRC-4 multiframe mark.
// Assumes mf_bnd is asserted only together with frm_stb.
module e1_ts16_alarm
    import e1_alm_pkg::*;
#(
    parameter int FRAMES      = 16,
    parameter int ZERO_MIN    = 3,
    parameter int MF_FRAMES   = 16,
    parameter int FREE_FRAMES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_stb,
    input  logic [7:0] ts16,
    input  logic       mf_bnd,
    input  logic       crc4_en,
    input  logic       crcmf_bnd,
    output logic       ones_hit,
    output logic       zeros_hit,
    output logic       cmf_hit
);
    localparam int FW = $clog2(FRAMES);
    localparam int ZW = $clog2(8 * FRAMES + 1);
    localparam int MW = $clog2(MF_FRAMES);
    localparam int RW = $clog2(FREE_FRAMES);

    logic [FW-1:0] win_q;
    logic [ZW-1:0] wz_q;
    logic [ZW-1:0] wz_nx;
    logic [MW-1:0] mf_q;
    logic          allz_q;
    logic [RW-1:0] free_q;
    logic          byte_zero;
    logic          win_last;
    logic          free_wrap;

    // Per-frame decisions for the three tests.
    always_comb begin
        byte_zero = (ts16 == 8'h00);
        wz_nx     = wz_q + ZW'(zero_bits(ts16));
        win_last  = frm_stb && (win_q == FW'(FRAMES - 1));
        ones_hit  = win_last && (wz_nx < ZW'(ZERO_MIN));
        zeros_hit = frm_stb && mf_bnd && (mf_q == MW'(MF_FRAMES - 1))
                    && allz_q && byte_zero;
        free_wrap = frm_stb && (free_q == RW'(FREE_FRAMES - 1));
        cmf_hit   = crc4_en ? crcmf_bnd : free_wrap;
    end

    // All-ones window: frames and zero bits seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            wz_q  <= '0;
        end else if (frm_stb) begin
            if (win_last) begin
                win_q <= '0;
                wz_q  <= '0;
            end else begin
                win_q <= win_q + 1'b1;
                wz_q  <= wz_nx;
            end
        end
    end

    // All-zeros tracking since the last multiframe boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mf_q   <= '0;
            allz_q <= 1'b1;
        end else if (frm_stb) begin
            if (mf_bnd) begin
                mf_q   <= '0;
                allz_q <= 1'b1;
            end else begin
                if (mf_q != MW'(MF_FRAMES - 1)) mf_q <= mf_q + 1'b1;
                allz_q <= allz_q && byte_zero;
            end
        end
    end

    // Free-running multiframe count used when CRC-4 is off.
    always_ff @(posedge clk) begin
        if (!rst_n)         free_q <= '0;
        else if (free_wrap) free_q <= '0;
        else if (frm_stb)   free_q <= free_q + 1'b1;
    end

    AST_SIGO_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ones_hit |-> frm_stb); // R4
    AST_SIGZ_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zeros_hit |-> (ts16 == 8'h00 && mf_bnd)); // R5
    AST_CMF_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc4_en && !frm_stb) |-> !cmf_hit); // R6
    AST_BND_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        mf_bnd |-> frm_stb); // R5
endmodule

// File: rtl/e1_status_latch.sv
// Sticky status byte with write-1-to-clear and a masked interrupt.
// Assumes event pulses are one cycle wide; an event beats a clear.
module e1_status_latch #(
    parameter int W     = 8,
    parameter int IRQ_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     ev,
    input  logic             clr_wr,
    input  logic [W-1:0]     clr_data,
    input  logic [IRQ_N-1:0] irq_mask,
    output logic [W-1:0]     status,
    output logic             irq
);
    logic [W-1:0] st_q;
    logic [W-1:0] clr_m;

    // Bits the host asks to clear this cycle.
    always_comb clr_m = clr_wr ? clr_data : '0;

    // Latch events and apply host clears.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_m) | ev;
    end

    // Interrupt from the enabled low bits.
    always_comb begin
        status = st_q;
        irq    = |(st_q[IRQ_N-1:0] & irq_mask);
    end

    AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((status & $past(status)) == $past(status))); // R9
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((status & $past(ev)) == $past(ev))); // R9
    AST_IRQ_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (status[IRQ_N-1:0] == '0) |-> !irq); // R10
endmodule

// File: rtl/e1_rx_alarm_mon.sv
// E1 receive resync criteria and signaling alarm monitor. Collects the
// event pulses of the criterion counters and time slot 16 tests into a
// sticky status byte. Assumes the framer's inputs are one-cycle strobes.
module e1_rx_alarm_mon
    import e1_alm_pkg::*;
#(
    parameter int FAS_LIMIT   = 3,
    parameter int CAS_LIMIT   = 2,
    parameter int CRC_WINDOW  = 1000,
    parameter int CRC_THRESH  = 915,
    parameter int SIG_FRAMES  = 16,
    parameter int SIG_ZMIN    = 3,
    parameter int MF_FRAMES   = 16,
    parameter int FREE_FRAMES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fas_vld,
    input  logic             fas_err,
    input  logic             cas_vld,
    input  logic             cas_err,
    input  logic             crc_vld,
    input  logic             crc_err,
    input  logic             frm_stb,
    input  logic [7:0]       ts16_data,
    input  logic             mf_bnd,
    input  logic             crcmf_bnd,
    input  logic             crc4_en,
    input  logic             algn_stb,
    input  logic             clr_wr,
    input  logic [STAT_W-1:0] clr_data,
    input  logic [IRQ_N-1:0] irq_mask,
    output logic [STAT_W-1:0] status,
    output logic             irq
);
    logic fas_hit, cas_hit, crc_hit, sigo_hit, sigz_hit, cmf_hit;
    logic [STAT_W-1:0] ev;

    e1_consec_err #(.LIMIT(FAS_LIMIT)) u_fas (
        .clk(clk), .rst_n(rst_n), .vld(fas_vld), .err(fas_err), .hit(fas_hit)
    );

    e1_consec_err #(.LIMIT(CAS_LIMIT)) u_cas (
        .clk(clk), .rst_n(rst_n), .vld(cas_vld), .err(cas_err), .hit(cas_hit)
    );

    e1_crc_window #(.WINDOW(CRC_WINDOW), .THRESH(CRC_THRESH)) u_crc (
        .clk(clk), .rst_n(rst_n), .vld(crc_vld), .err(crc_err), .hit(crc_hit)
    );

    e1_ts16_alarm #(
        .FRAMES(SIG_FRAMES), .ZERO_MIN(SIG_ZMIN),
        .MF_FRAMES(MF_FRAMES), .FREE_FRAMES(FREE_FRAMES)
    ) u_ts16 (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .ts16(ts16_data),
        .mf_bnd(mf_bnd), .crc4_en(crc4_en), .crcmf_bnd(crcmf_bnd),
        .ones_hit(sigo_hit), .zeros_hit(sigz_hit), .cmf_hit(cmf_hit)
    );

    // Place each event pulse at its status bit; the top bit stays idle.
    always_comb begin
        ev            = '0;
        ev[B_ALIGN]   = algn_stb;
        ev[B_CRCMF]   = cmf_hit;
        ev[B_SIGZ]    = sigz_hit;
        ev[B_SIGO]    = sigo_hit;
        ev[B_FASCRIT] = fas_hit;
        ev[B_CASCRIT] = cas_hit;
        ev[B_CRCCRIT] = crc_hit;
    end

    e1_status_latch #(.W(STAT_W), .IRQ_N(IRQ_N)) u_stat (
        .clk(clk), .rst_n(rst_n), .ev(ev), .clr_wr(clr_wr),
        .clr_data(clr_data), .irq_mask(irq_mask), .status(status), .irq(irq)
    );

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_W-1] == 1'b0); // R8
    AST_ALIGN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        algn_stb |=> status[B_ALIGN]); // R7
    AST_FAS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fas_hit |=> status[B_FASCRIT]); // R1
endmodule

// File: tb/test_e1_rx_alarm_mon.sv
module test_e1_rx_alarm_mon;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fas_vld = 0, fas_err = 0, cas_vld = 0, cas_err = 0;
    logic       crc_vld = 0, crc_err = 0, frm_stb = 0, mf_bnd = 0;
    logic       crcmf_bnd = 0, crc4_en = 1, algn_stb = 0, clr_wr = 0;
    logic [7:0] ts16_data = 8'h55, clr_data = 8'h00;
    logic [3:0] irq_mask = 4'hF;
    logic [7:0] status;
    logic       irq;

    int checks = 0, errors = 0;
    bit done = 0;

    // Behavioural reference state
    int fas_run = 0, cas_run = 0, crc_blk = 0, crc_errs = 0;
    int w_fr = 0, w_z = 0, mf_seen = 0, free_fr = 0;
    bit allz = 1;
    logic [7:0] exp_st = 8'h00;

    always #5 clk = ~clk;

    e1_rx_alarm_mon i_e1_rx_alarm_mon (
        .clk(clk), .rst_n(rst_n), .fas_vld(fas_vld), .fas_err(fas_err),
        .cas_vld(cas_vld), .cas_err(cas_err), .crc_vld(crc_vld), .crc_err(crc_err),
        .frm_stb(frm_stb), .ts16_data(ts16_data), .mf_bnd(mf_bnd),
        .crcmf_bnd(crcmf_bnd), .crc4_en(crc4_en), .algn_stb(algn_stb),
        .clr_wr(clr_wr), .clr_data(clr_data), .irq_mask(irq_mask),
        .status(status), .irq(irq)
    );

    function automatic string req_of(int b);
        case (b)
            0: return "R7";  1: return "R6";  2: return "R5";  3: return "R4";
            4: return "R1";  5: return "R2";  6: return "R3";  default: return "R8";
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic compare();
        int fb;
        logic exp_irq;
        fb = -1;
        for (int b = 7; b >= 0; b--) if (status[b] !== exp_st[b]) fb = b;
        check(fb < 0, (fb < 0) ? "R9" : req_of(fb), status, exp_st);
        exp_irq = |(exp_st[3:0] & irq_mask);
        check(irq === exp_irq, "R10", irq, exp_irq);
    endtask

    // Advance one clock with the current inputs and compare the model.
    task automatic step();
        logic [7:0] ev;
        int z;
        ev = 8'h00;
        if (fas_vld) begin
            if (fas_err) begin
                fas_run++;
                if (fas_run == 3) begin ev[4] = 1; fas_run = 0; end
            end else fas_run = 0;
        end
        if (cas_vld) begin
            if (cas_err) begin
                cas_run++;
                if (cas_run == 2) begin ev[5] = 1; cas_run = 0; end
            end else cas_run = 0;
        end
        if (crc_vld) begin
            crc_blk++;
            if (crc_err) crc_errs++;
            if (crc_blk == 1000) begin
                if (crc_errs >= 915) ev[6] = 1;
                crc_blk = 0; crc_errs = 0;
            end
        end
        if (frm_stb) begin
            z = 0;
            for (int i = 0; i < 8; i++) if (!ts16_data[i]) z++;
            w_fr++; w_z += z;
            if (w_fr == 16) begin
                if (w_z < 3) ev[3] = 1;
                w_fr = 0; w_z = 0;
            end
            if (mf_bnd) begin
                if (mf_seen >= 15 && allz && ts16_data == 8'h00) ev[2] = 1;
                mf_seen = 0; allz = 1;
            end else begin
                mf_seen++;
                allz = allz && (ts16_data == 8'h00);
            end
            free_fr++;
            if (free_fr == 16) begin
                free_fr = 0;
                if (!crc4_en) ev[1] = 1;
            end
        end
        if (crc4_en && crcmf_bnd) ev[1] = 1;
        if (algn_stb) ev[0] = 1;
        @(posedge clk);
        exp_st = (exp_st & ~(clr_wr ? clr_data : 8'h00)) | ev;
        exp_st[7] = 1'b0;
        @(negedge clk);
        compare();
    endtask

    task automatic quiet();
        fas_vld = 0; cas_vld = 0; crc_vld = 0; frm_stb = 0; mf_bnd = 0;
        crcmf_bnd = 0; algn_stb = 0; clr_wr = 0;
    endtask

    task automatic clear_all();
        quiet(); clr_wr = 1; clr_data = 8'hFF; step(); clr_wr = 0;
    endtask

    task automatic fas(bit e);
        quiet(); fas_vld = 1; fas_err = e; step(); fas_vld = 0;
    endtask

    task automatic cas(bit e);
        quiet(); cas_vld = 1; cas_err = e; step(); cas_vld = 0;
    endtask

    task automatic frame(logic [7:0] d, bit bnd);
        quiet(); frm_stb = 1; ts16_data = d; mf_bnd = bnd; step();
        frm_stb = 0; mf_bnd = 0;
    endtask

    task automatic crc_window(int nerr);
        quiet();
        for (int i = 0; i < 1000; i++) begin
            crc_vld = 1; crc_err = (i < nerr); step();
        end
        crc_vld = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        check(status === 8'h00, "R8", status, 0);
        check(irq === 1'b0, "R8", irq, 0);

        // R3: windows with 920, 900 and exactly 915 errors
        crc_window(920);
        check(status[6] === 1'b1, "R3", status[6], 1);
        clear_all();
        crc_window(900);
        check(status[6] === 1'b0, "R3", status[6], 0);
        crc_window(915);
        check(status[6] === 1'b1, "R3", status[6], 1);
        clear_all();

        // R1: a good word breaks the run, three in a row hits
        fas(1); fas(1); fas(0); fas(1); fas(1);
        check(status[4] === 1'b0, "R1", status[4], 0);
        fas(1);
        check(status[4] === 1'b1, "R1", status[4], 1);
        // R10: criterion bits do not interrupt
        check(irq === 1'b0, "R10", irq, 0);
        clear_all();

        // R2
        cas(1); cas(0); cas(1);
        check(status[5] === 1'b0, "R2", status[5], 0);
        cas(1);
        check(status[5] === 1'b1, "R2", status[5], 1);
        clear_all();

        // R4: two zeros in a window hits, three does not
        for (int i = 0; i < 16; i++) frame((i == 3 || i == 9) ? 8'hFE : 8'hFF, 0);
        check(status[3] === 1'b1, "R4", status[3], 1);
        clear_all();
        for (int i = 0; i < 16; i++) frame((i == 1) ? 8'hF8 : 8'hFF, 0);
        check(status[3] === 1'b0, "R4", status[3], 0);

        // R5: first boundary follows nonzero octets, second follows a full zero MF
        for (int i = 0; i < 16; i++) frame(8'h00, i == 15);
        check(status[2] === 1'b0, "R5", status[2], 0);
        for (int i = 0; i < 16; i++) frame(8'h00, i == 15);
        check(status[2] === 1'b1, "R5", status[2], 1);
        clear_all();
        for (int i = 0; i < 10; i++) frame(8'h00, i == 9);
        check(status[2] === 1'b0, "R5", status[2], 0);
        clear_all();

        // R6: free-running mark with CRC-4 off, boundary strobe ignored
        crc4_en = 0;
        quiet(); crcmf_bnd = 1; step(); crcmf_bnd = 0;
        check(status[1] === 1'b0, "R6", status[1], 0);
        for (int i = 0; i < 40; i++) frame(8'h55, 0);
        crc4_en = 1;
        clear_all();
        quiet(); crcmf_bnd = 1; step(); crcmf_bnd = 0;
        check(status[1] === 1'b1, "R6", status[1], 1);

        // R7 and R9: align strobe in the same cycle as its clear
        quiet(); algn_stb = 1; clr_wr = 1; clr_data = 8'h03; step();
        quiet();
        check(status[0] === 1'b1, "R9", status[0], 1);
        check(status[1] === 1'b0, "R9", status[1], 0);
        irq_mask = 4'b0010;
        step();
        check(irq === 1'b0, "R10", irq, 0);
        irq_mask = 4'b0001;
        step();
        check(irq === 1'b1, "R10", irq, 1);

        // Mixed random traffic, compared every cycle
        for (int n = 0; n < 6000; n++) begin
            quiet();
            fas_vld = ($urandom % 3) == 0; fas_err = ($urandom % 3) != 0;
            cas_vld = ($urandom % 5) == 0; cas_err = ($urandom % 2) == 0;
            crc_vld = ($urandom % 2) == 0; crc_err = ($urandom % 20) != 0;
            frm_stb = ($urandom % 2) == 0;
            ts16_data = (($urandom % 3) == 0) ? 8'h00 :
                        (($urandom % 2) == 0) ? 8'hFF : 8'($urandom);
            mf_bnd = frm_stb && (($urandom % 16) == 0);
            crcmf_bnd = ($urandom % 40) == 0;
            algn_stb = ($urandom % 30) == 0;
            if ((n % 500) == 0) crc4_en = ~crc4_en;
            if ((n % 97) == 0) irq_mask = 4'($urandom);
            clr_wr = ($urandom % 10) == 0; clr_data = 8'($urandom);
            step();
        end
        quiet();
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule